// File: doc/BRIEF.md
# Mode-0 Parallel Port Group

This block is one 24-line digital I/O group on a byte-wide register bus. It holds three 8-bit ports. Port C is split into two nibbles, and each nibble has its own direction. A write-only control register sets the direction of each port or nibble, and software writes it at initialisation. Writes to a port's offset load that port's output latch. Reads of a port are combinational. Lines set as outputs return the latch contents. Lines set as inputs return the live pad value, with no latching.

A one-bit buffer controller gates the output enables of the line buffers. A control write with bit 7 high is a mode-set write. It reprograms every direction, clears all output latches and disables the buffers in the same edge. Software then loads the output values while the lines are still tristated. A control write with bit 7 low touches only the buffer controller, which enables the buffers. A second register at offset 4 loads the controller from bit 7 in either direction and never changes directions or data. A strap input overrides the controller and keeps the buffers always enabled. Each pad line gets a direction flag and an output enable. The enable is high only when the line is an output and the buffers are enabled.

Top module: `pio_group`

## Requirements
- R1: After synchronous reset every line is an input (`pad_dir` all ones), all output latches are zero, the buffer controller holds the enabled state (`buf_en` = 1) and `pad_oe` is all zeros.
- R2: A bus write to offset 0, 1 or 2 loads the latch of port A, B or C. `pad_out[7:0]` carries port A, `pad_out[15:8]` port B and `pad_out[23:16]` port C.
- R3: A control write (offset 3) with bit 7 set programs the directions from its data bits. Bit 4 sets port A, bit 1 port B, bit 3 the C high nibble and bit 0 the C low nibble. A 1 selects input and a 0 selects output.
- R4: A control write with bit 7 set clears all three output latches to zero and disables the buffers, both on the same clock edge.
- R5: A control write with bit 7 clear leaves the directions and latches unchanged and enables the buffers.
- R6: A write to offset 4 disables the buffers when bit 7 is 1 and enables them when bit 7 is 0. It leaves directions and latches unchanged.
- R7: While `strap_buf_on` is high, `buf_en` is 1 whatever the buffer controller holds. While it is low, `buf_en` is the inverse of the controller's disable state.
- R8: `pad_oe[i]` is 1 exactly when line i is an output and `buf_en` is 1.
- R9: A read of offset 0, 1 or 2 returns, combinationally in the same cycle, the latch bit for output lines and the live `pad_in` bit for input lines. This works per nibble of port C.
- R10: Data bits 2, 5 and 6 of a control write have no effect. Only mode 0 exists.
- R11: Reads of offsets 3 to 7 return 0. Writes to offsets 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| strap_buf_on | input | 1 | Forces the line buffers enabled |
| pad_in | input | 24 | Live pad levels |
| pad_out | output | 24 | Output latch contents |
| pad_dir | output | 24 | Per-line direction, 1 = input |
| pad_oe | output | 24 | Per-line output enable |
| buf_en | output | 1 | Effective buffer enable |

## Verification
The bench programs a mix in which the two C nibbles have opposite directions. A design that treats port C as one unit would then return latch bits where pad bits belong. It sends control bytes with bit 7 low and with different data bits, so a design that reprograms directions or clears latches on those writes shows the wrong read-back. It also sets bits 2, 5 and 6, which a design that decodes a mode would mishandle. The offset-4 register, the strap override and the output-enable gating are each checked at the pads. This catches any enable that leaks while the buffers are disabled, and any missing clear of the latches on a mode-set write.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_PORTS = 3;
    localparam int LINES     = BYTE_W * NUM_PORTS;
    localparam int NIB_W     = BYTE_W / 2;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_BUF  = 3'd4;

    localparam int CB_CLO = 0;
    localparam int CB_B   = 1;
    localparam int CB_CHI = 3;
    localparam int CB_A   = 4;
    localparam int CB_SET = 7;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_cfg_t;

    localparam dir_cfg_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};

    function automatic dir_cfg_t decode_ctrl(input logic [BYTE_W-1:0] b);
        dir_cfg_t d;
        d.a_in   = b[CB_A];
        d.b_in   = b[CB_B];
        d.chi_in = b[CB_CHI];
        d.clo_in = b[CB_CLO];
        return d;
    endfunction

    function automatic logic [LINES-1:0] input_mask(input dir_cfg_t d);
        return {{NIB_W{d.chi_in}}, {NIB_W{d.clo_in}}, {BYTE_W{d.b_in}}, {BYTE_W{d.a_in}}};
    endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] wdata,
    output dir_cfg_t          dir,
    output logic              buf_dis
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir     <= DIR_RESET;
            buf_dis <= 1'b0;
        end else if (ctrl_wr) begin
            buf_dis <= wdata[CB_SET];
            if (wdata[CB_SET]) dir <= decode_ctrl(wdata);
        end else if (buf_wr) begin
            buf_dis <= wdata[CB_SET];
        end
    end

    // R4
    mode_set_disables_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[CB_SET]) |=> buf_dis);
    // R5
    plain_ctrl_keeps_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata[CB_SET]) |=> ($stable(dir) && !buf_dis));
    // R6
    buf_reg_keeps_dir_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr |=> $stable(dir));
endmodule

// File: rtl/pio_latch.sv
module pio_latch
    import pio_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int N = NUM_PORTS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   port_wr,
    input  logic           clear,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] latch
);
    for (genvar p = 0; p < N; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst || clear)     latch[p*W +: W] <= '0;
            else if (port_wr[p])  latch[p*W +: W] <= wdata;
        end
    end

    // R4
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (latch == '0));
    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_wr));
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  latch,
    input  logic [LINES-1:0]  pad_in,
    input  logic [LINES-1:0]  in_mask,
    output logic [BYTE_W-1:0] rdata
);
    logic [LINES-1:0] view;

    always_comb begin
        view  = (pad_in & in_mask) | (latch & ~in_mask);
        rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (addr == ADDR_W'(p)) rdata = view[p*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              strap_buf_on,
    input  logic [23:0]       pad_in,
    output logic [23:0]       pad_out,
    output logic [23:0]       pad_dir,
    output logic [23:0]       pad_oe,
    output logic              buf_en
);
    dir_cfg_t             dir;
    logic                 buf_dis;
    logic                 ctrl_wr;
    logic                 buf_wr;
    logic [NUM_PORTS-1:0] port_wr;
    logic [LINES-1:0]     latch;

    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign buf_wr  = bus_wr && (bus_addr == OFS_BUF);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign port_wr[p] = bus_wr && (bus_addr == ADDR_W'(p));
    end

    pio_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .buf_wr  (buf_wr),
        .wdata   (bus_wdata),
        .dir     (dir),
        .buf_dis (buf_dis)
    );

    pio_latch #(.W(BYTE_W), .N(NUM_PORTS)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .port_wr (port_wr),
        .clear   (ctrl_wr && bus_wdata[CB_SET]),
        .wdata   (bus_wdata),
        .latch   (latch)
    );

    assign pad_dir = input_mask(dir);
    assign buf_en  = strap_buf_on || !buf_dis;
    assign pad_out = latch;
    assign pad_oe  = ~pad_dir & {LINES{buf_en}};

    pio_rdmux u_rd (
        .addr    (bus_addr),
        .latch   (latch),
        .pad_in  (pad_in),
        .in_mask (pad_dir),
        .rdata   (bus_rdata)
    );

    // R8
    oe_only_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_dir) == '0);
    // R8
    oe_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !buf_en |-> (pad_oe == '0));
    // R7
    strap_forces_on_chk: assert property (@(posedge clk) disable iff (rst)
        strap_buf_on |-> buf_en);
endmodule

// File: tb/pio_group_test.sv
module pio_group_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        strap_buf_on = 1'b0;
    logic [23:0] pad_in = 24'hC35A96;
    logic [23:0] pad_out, pad_dir, pad_oe;
    logic        buf_en;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pio_group uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_buf_on(strap_buf_on),
        .pad_in(pad_in), .pad_out(pad_out), .pad_dir(pad_dir), .pad_oe(pad_oe),
        .buf_en(buf_en)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        {1'b0, 3'd0, 8'h96, 4'd1},  // R1 input after reset
        {1'b1, 3'd3, 8'h89, 4'd0},  // A,B out; C in
        {1'b0, 3'd0, 8'h00, 4'd4},  // R4 latch cleared
        {1'b1, 3'd0, 8'h3C, 4'd0},
        {1'b0, 3'd0, 8'h3C, 4'd2},  // R2
        {1'b1, 3'd1, 8'hA5, 4'd0},
        {1'b0, 3'd1, 8'hA5, 4'd2},  // R2
        {1'b0, 3'd2, 8'hC3, 4'd3},  // R3 C input
        {1'b1, 3'd2, 8'h0F, 4'd0},
        {1'b0, 3'd2, 8'hC3, 4'd9},  // R9 pads win over latch
        {1'b1, 3'd3, 8'h92, 4'd0},  // A,B in; C out
        {1'b0, 3'd0, 8'h96, 4'd3},  // R3
        {1'b0, 3'd1, 8'h5A, 4'd3},  // R3
        {1'b0, 3'd2, 8'h00, 4'd4},  // R4
        {1'b1, 3'd2, 8'h7E, 4'd0},
        {1'b1, 3'd3, 8'h81, 4'd0},  // only C low in
        {1'b0, 3'd2, 8'h03, 4'd3},  // R3 nibble split
        {1'b1, 3'd2, 8'hB0, 4'd0},
        {1'b0, 3'd2, 8'hB3, 4'd9},  // R9
        {1'b1, 3'd0, 8'h44, 4'd0},
        {1'b1, 3'd3, 8'h16, 4'd0},  // bit 7 low
        {1'b0, 3'd2, 8'hB3, 4'd5},  // R5
        {1'b0, 3'd0, 8'h44, 4'd5},  // R5
        {1'b1, 3'd3, 8'hE5, 4'd0},  // mode bits set
        {1'b0, 3'd2, 8'h03, 4'd10}, // R10
        {1'b0, 3'd1, 8'h00, 4'd10}, // R10
        {1'b0, 3'd3, 8'h00, 4'd11}, // R11
        {1'b0, 3'd4, 8'h00, 4'd11}, // R11
        {1'b0, 3'd6, 8'h00, 4'd11}, // R11
        {1'b1, 3'd6, 8'hFF, 4'd0},
        {1'b0, 3'd0, 8'h00, 4'd11}, // R11
        {1'b1, 3'd7, 8'hFF, 4'd0},
        {1'b0, 3'd2, 8'h03, 4'd11}  // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 dir", pad_dir, 24'hFFFFFF);
        check("R1 oe", pad_oe, 24'h0);
        check("R1 out", pad_out, 24'h0);
        check("R1 buf", buf_en, 1'b1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].data);
            end
        end

        // state: A,B,Chi out, Clo in, buffers disabled
        check("R4 buf off", buf_en, 1'b0);
        check("R8 oe off", pad_oe, 24'h0);
        strap_buf_on = 1'b1; #1;
        check("R7 strap", buf_en, 1'b1);
        check("R8 oe strap", pad_oe, 24'hF0FFFF);
        strap_buf_on = 1'b0;
        bus_write(3'd4, 8'h7F);
        check("R6 enable", pad_oe, 24'hF0FFFF);
        check("R6 dir", pad_dir, 24'h0F0000);
        bus_write(3'd0, 8'h11);
        bus_write(3'd4, 8'h80);
        check("R6 disable", pad_oe, 24'h0);
        bus_read(3'd0, rd);
        check("R6 data", rd, 8'h11);
        bus_write(3'd3, 8'h00);
        check("R5 enable", pad_oe, 24'hF0FFFF);
        check("R5 latch", pad_out, 24'h000011);
        bus_write(3'd1, 8'h22);
        check("R2 out B", pad_out, 24'h002211);
        bus_write(3'd3, 8'h80);
        check("R4 clear", pad_out, 24'h0);
        check("R4 oe", pad_oe, 24'h0);
        check("R3 all out", pad_dir, 24'h0);
        bus_write(3'd3, 8'h9B);
        pad_in = 24'h123456;
        bus_read(3'd0, rd);
        check("R9 live", rd, 8'h56);
        pad_in = 24'h12345A;
        bus_read(3'd0, rd);
        check("R9 live2", rd, 8'h5A);
        bus_write(3'd0, 8'hAA);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1 dir again", pad_dir, 24'hFFFFFF);
        check("R1 out again", pad_out, 24'h0);
        check("R1 buf again", buf_en, 1'b1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule